// File: doc/BRIEF.md
# Watchdog and Reset Generator

This block is the reset controller of a small 4-bit microcontroller core. It divides the system clock into machine-cycle ticks, where a machine cycle is six input clocks. An option input slows the tick to one every 48 clocks. A binary watchdog counter of `CNT_W` stages counts these ticks. When the counter's top stage sets, which happens after 2^(CNT_W-1) ticks, the block drives its internal CPU reset. It then keeps that reset asserted for a fixed four machine cycles and releases it. A sticky timeout flag records that the watchdog fired.

Software keeps the watchdog from firing in one of two ways. The instruction decoder can raise a clear strobe. Alternatively, when a configuration option is set, the core can perform a port-set operation while its port-select value equals 8. While the core sits in STOP mode, both the counter and the prescaler are held at zero, so counting starts again from zero once STOP ends.

The block also filters the external active-low reset pin. The pin passes through a two-stage synchronizer. It is accepted as a reset only after it has stayed low for more than `PIN_MIN` clocks, which is four machine cycles. Reset sequencing uses a three-state machine:
- `ST_RUN` is normal operation.
- `ST_PIN_RST` lasts while a qualified pin reset is present.
- `ST_HOLD` is a fixed-length reset tail.

The machine has these transitions:
- RUN→HOLD on a watchdog timeout.
- RUN→PIN_RST and HOLD→PIN_RST when the filtered pin is accepted.
- PIN_RST→HOLD when the pin is released.
- HOLD→RUN once the tail count expires.

Power-on enters `ST_HOLD`.

Top module: `wdt_reset_ctrl`

## Requirements
- R1: While `por_n` is low, `cpu_rst` is 1 and `wdt_timeout` is 0. After `por_n` rises, `cpu_rst` stays 1 for `HOLD_MC` machine cycles (24 clocks by default) and then falls to 0.
- R2: With `osc_slow`=0, the prescaler ticks once every `MC_CLKS` (6) clocks. The watchdog times out 2^(CNT_W-1) ticks after its last clear.
- R3: With `osc_slow`=1, the prescaler ticks once every `MC_CLKS*SLOW_MULT` (48) clocks. The timeout therefore arrives eight times later than in R2.
- R4: A timeout drives `cpu_rst` to 1 for `HOLD_MC` machine cycles, then releases it. The counter and the prescaler are held at zero while `cpu_rst` is 1.
- R5: `wdt_timeout` becomes 1 when a timeout occurs. It stays 1 until `wdt_clr` is pulsed or an accepted port clear (R7) occurs, either of which returns it to 0.
- R6: A one-cycle pulse on `wdt_clr` resets the watchdog counter to zero. Clears repeated well inside the timeout period prevent any timeout.
- R7: When `port_clr_en`=1, a `port_set_stb` pulse with `port_sel`=8 (4-bit value) clears the counter in the same way as R6.
- R8: A `port_set_stb` pulse has no effect on the counter when `port_sel`≠8 or when `port_clr_en`=0. In either case the watchdog still times out.
- R9: While `stop_mode`=1, the counter stays at zero and no timeout occurs. After `stop_mode` falls, the full timeout period of R2 elapses before a timeout.
- R10: If `ext_rst_n` stays low for more than `PIN_MIN` (24) clocks, `cpu_rst` becomes 1. `cpu_rst` stays 1 while the pin is low and for `HOLD_MC` machine cycles after the pin returns high.
- R11: A low pulse on `ext_rst_n` shorter than `PIN_MIN` clocks leaves `cpu_rst` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| osc_slow | input | 1 | Tick rate option: 0 selects clock/6, 1 selects clock/48 |
| wdt_clr | input | 1 | Watchdog clear strobe from the instruction decoder |
| port_clr_en | input | 1 | Configuration option that lets a port write clear the watchdog |
| port_set_stb | input | 1 | Port-set operation strobe |
| port_sel | input | 4 | Port-select register value |
| stop_mode | input | 1 | Core is in STOP mode |
| cpu_rst | output | 1 | Internal CPU reset, active high |
| wdt_timeout | output | 1 | Sticky flag set by a watchdog timeout |

## Verification
The bench targets the exact clear decode. A port strobe with the wrong select value, or with the option off, must still let the timeout through. A design that decoded only the select value, or ignored the enable, would suppress the reset.

Long runs held in STOP mode would expose a counter that keeps counting, or that resumes from a stale value. A 20-clock pin pulse checks the glitch filter: a design with a short or missing filter would reset the core on that pulse. A long pin pulse and a timeout both check the reset tail. A design that dropped the reset at once would fail the sample taken inside the tail.

The slow option is timed on both sides of the expected timeout. This catches a prescaler stuck at one rate.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Reset sequencer states
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_PIN_RST = 2'd1,
        ST_HOLD    = 2'd2
    } rst_state_t;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int MC_CLKS   = 6,
    parameter int SLOW_MULT = 8
) (
    input  logic clk,
    input  logic por_n,
    input  logic slow_sel,
    input  logic hold,
    output logic tick
);
    localparam int DIV_SLOW = MC_CLKS * SLOW_MULT;
    localparam int PW       = $clog2(DIV_SLOW);

    logic [PW-1:0] div_cnt;
    logic [PW-1:0] last_val;

    assign last_val = slow_sel ? PW'(DIV_SLOW - 1) : PW'(MC_CLKS - 1);

    // >= so a switch to the fast rate mid-count wraps at once
    assign tick = !hold && (div_cnt >= last_val);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            div_cnt <= '0;
        end else if (hold || (div_cnt >= last_val)) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             tick,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             overflow
);
    // The top stage sets after 2^(CNT_W-1) ticks
    assign overflow = cnt[CNT_W-1];

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_pin_filter.sv
module wdt_pin_filter #(
    parameter int MIN_LOW = 24
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_n,
    output logic accept
);
    localparam int LIM = MIN_LOW + 1;
    localparam int CW  = $clog2(LIM + 1);

    logic          sync1;
    logic          sync2;
    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= pin_n;
            sync2 <= sync1;
        end
    end

    // Count synchronized low cycles, saturating once accepted
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            low_cnt <= '0;
        end else if (sync2) begin
            low_cnt <= '0;
        end else if (low_cnt != CW'(LIM)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign accept = (low_cnt == CW'(LIM));

endmodule

// File: rtl/wdt_reset_ctrl.sv
module wdt_reset_ctrl
    import wdt_pkg::*;
#(
    parameter int MC_CLKS    = 6,
    parameter int SLOW_MULT  = 8,
    parameter int CNT_W      = 14,
    parameter int HOLD_MC    = 4,
    parameter int PIN_MIN    = 24,
    parameter int SEL_W      = 4,
    parameter int PORT_MATCH = 8
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             ext_rst_n,
    input  logic             osc_slow,
    input  logic             wdt_clr,
    input  logic             port_clr_en,
    input  logic             port_set_stb,
    input  logic [SEL_W-1:0] port_sel,
    input  logic             stop_mode,
    output logic             cpu_rst,
    output logic             wdt_timeout
);
    localparam int HOLD_CLKS = MC_CLKS * HOLD_MC;
    localparam int HW        = $clog2(HOLD_CLKS + 1);

    rst_state_t       state;
    rst_state_t       state_nx;
    logic [HW-1:0]    hold_cnt;
    logic             pin_ok;
    logic             wdt_tick;
    logic             wdt_ovf;
    logic [CNT_W-1:0] wdt_cnt;
    logic             port_hit;
    logic             soft_clr;
    logic             timeout_evt;
    logic             hold_done;

    assign port_hit = port_clr_en && port_set_stb &&
                      (port_sel == SEL_W'(PORT_MATCH));
    assign soft_clr = wdt_clr || port_hit;

    wdt_pin_filter #(.MIN_LOW(PIN_MIN)) u_pin (
        .clk    (clk),
        .por_n  (por_n),
        .pin_n  (ext_rst_n),
        .accept (pin_ok)
    );

    wdt_prescaler #(.MC_CLKS(MC_CLKS), .SLOW_MULT(SLOW_MULT)) u_pre (
        .clk      (clk),
        .por_n    (por_n),
        .slow_sel (osc_slow),
        .hold     (stop_mode || cpu_rst),
        .tick     (wdt_tick)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .por_n    (por_n),
        .tick     (wdt_tick),
        .clr      (soft_clr || stop_mode || cpu_rst),
        .cnt      (wdt_cnt),
        .overflow (wdt_ovf)
    );

    assign hold_done = (hold_cnt == HW'(HOLD_CLKS - 1));

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (pin_ok)       state_nx = ST_PIN_RST;
                else if (wdt_ovf) state_nx = ST_HOLD;
            end
            ST_PIN_RST: begin
                if (!pin_ok)      state_nx = ST_HOLD;
            end
            ST_HOLD: begin
                if (pin_ok)         state_nx = ST_PIN_RST;
                else if (hold_done) state_nx = ST_RUN;
            end
            default: state_nx = ST_HOLD;
        endcase
    end

    // State register and reset-tail counter
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state    <= ST_HOLD;
            hold_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_HOLD && state_nx == ST_HOLD) begin
                hold_cnt <= hold_cnt + 1'b1;
            end else begin
                hold_cnt <= '0;
            end
        end
    end

    // Output decode
    always_comb begin
        cpu_rst     = (state != ST_RUN);
        timeout_evt = (state == ST_RUN) && !pin_ok && wdt_ovf;
    end

    // Sticky timeout flag
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            wdt_timeout <= 1'b0;
        end else if (timeout_evt) begin
            wdt_timeout <= 1'b1;
        end else if (soft_clr) begin
            wdt_timeout <= 1'b0;
        end
    end

endmodule

// File: rtl/wdt_reset_chk.sv
module wdt_reset_chk (
    input logic clk,
    input logic por_n,
    input logic stop_mode,
    input logic soft_clr,
    input logic cnt_zero,
    input logic overflow,
    input logic tick,
    input logic pin_ok,
    input logic cpu_rst,
    input logic wdt_timeout
);
    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!por_n)
        tick |=> !tick); // R2

    AST_OVF_RESET: assert property (@(posedge clk) disable iff (!por_n)
        overflow |=> cpu_rst); // R4

    AST_RST_CNT_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        cpu_rst |=> cnt_zero); // R4

    AST_FLAG_WITH_RST: assert property (@(posedge clk) disable iff (!por_n)
        $rose(wdt_timeout) |-> cpu_rst); // R5

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        soft_clr |=> cnt_zero); // R6

    AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        stop_mode |=> cnt_zero); // R9

    AST_PIN_RESET: assert property (@(posedge clk) disable iff (!por_n)
        pin_ok |=> cpu_rst); // R10

endmodule

bind wdt_reset_ctrl wdt_reset_chk u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .stop_mode   (stop_mode),
    .soft_clr    (soft_clr),
    .cnt_zero    (wdt_cnt == '0),
    .overflow    (wdt_ovf),
    .tick        (wdt_tick),
    .pin_ok      (pin_ok),
    .cpu_rst     (cpu_rst),
    .wdt_timeout (wdt_timeout)
);

// File: tb/wdt_reset_ctrl_test.sv
module wdt_reset_ctrl_test;

    localparam int CNT_W = 6;   // 32 ticks to timeout: 192 clocks fast, 1536 slow

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       osc_slow = 1'b0;
    logic       wdt_clr = 1'b0;
    logic       port_clr_en = 1'b0;
    logic       port_set_stb = 1'b0;
    logic [3:0] port_sel = 4'd0;
    logic       stop_mode = 1'b0;
    logic       cpu_rst;
    logic       wdt_timeout;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        int    when;
        bit    chk_rst;
        bit    exp_rst;
        bit    chk_flag;
        bit    exp_flag;
        string req;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #2 clk = ~clk;   // 250 MHz

    wdt_reset_ctrl #(.CNT_W(CNT_W)) uut (
        .clk          (clk),
        .por_n        (por_n),
        .ext_rst_n    (ext_rst_n),
        .osc_slow     (osc_slow),
        .wdt_clr      (wdt_clr),
        .port_clr_en  (port_clr_en),
        .port_set_stb (port_set_stb),
        .port_sel     (port_sel),
        .stop_mode    (stop_mode),
        .cpu_rst      (cpu_rst),
        .wdt_timeout  (wdt_timeout)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every expectation due in this cycle
    always @(negedge clk) begin
        for (int i = sb_q.size() - 1; i >= 0; i--) begin
            if (sb_q[i].when == cyc) begin
                if (sb_q[i].chk_rst) begin
                    checks++;
                    if (cpu_rst !== sb_q[i].exp_rst) begin
                        failures++;
                        $display("FAIL %s cpu_rst actual=%b expected=%b cyc=%0d",
                                 sb_q[i].req, cpu_rst, sb_q[i].exp_rst, cyc);
                    end
                end
                if (sb_q[i].chk_flag) begin
                    checks++;
                    if (wdt_timeout !== sb_q[i].exp_flag) begin
                        failures++;
                        $display("FAIL %s wdt_timeout actual=%b expected=%b cyc=%0d",
                                 sb_q[i].req, wdt_timeout, sb_q[i].exp_flag, cyc);
                    end
                end
                sb_q.delete(i);
            end
        end
    end

    // Driver side: push an expectation dly cycles from now
    task automatic expect_at(input int dly, input bit cr, input bit er,
                             input bit cf, input bit ef, input string req);
        exp_item_t it;
        it.when = cyc + dly;
        it.chk_rst = cr;
        it.exp_rst = er;
        it.chk_flag = cf;
        it.exp_flag = ef;
        it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_clr();
        wdt_clr = 1'b1;
        step(1);
        wdt_clr = 1'b0;
    endtask

    task automatic port_write(input bit en, input logic [3:0] sel);
        port_clr_en = en;
        port_sel = sel;
        port_set_stb = 1'b1;
        step(1);
        port_set_stb = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog run did not complete");
        finish_run();
    end

    initial begin
        step(1);
        // R1: power-on state
        expect_at(2, 1, 1, 1, 0, "R1");
        step(4);
        por_n = 1'b1;
        expect_at(10, 1, 1, 0, 0, "R1");
        expect_at(40, 1, 0, 1, 0, "R1");
        step(45);

        // R2/R4/R5: fast timeout and reset tail
        pulse_clr();
        expect_at(170, 1, 0, 1, 0, "R2");
        expect_at(205, 1, 1, 0, 0, "R4");
        expect_at(215, 0, 0, 1, 1, "R2");
        expect_at(250, 1, 0, 1, 1, "R5");
        step(260);

        // R6: periodic clear strobe
        pulse_clr();
        for (int k = 0; k < 6; k++) begin
            expect_at(50, 1, 0, 1, 0, "R6");
            step(100);
            pulse_clr();
        end

        // R7: port clear with option set and select 8
        for (int k = 0; k < 6; k++) begin
            expect_at(50, 1, 0, 1, 0, "R7");
            step(100);
            port_write(1'b1, 4'd8);
        end

        // R8: wrong select value does not clear
        pulse_clr();
        expect_at(250, 0, 0, 1, 1, "R8");
        for (int k = 0; k < 4; k++) begin
            step(60);
            port_write(1'b1, 4'd7);
        end
        step(20);
        // R5: accepted port clear drops the flag
        port_write(1'b1, 4'd8);
        expect_at(2, 0, 0, 1, 0, "R5");
        step(3);

        // R8: option off, select 8 does not clear
        expect_at(250, 0, 0, 1, 1, "R8");
        for (int k = 0; k < 4; k++) begin
            step(60);
            port_write(1'b0, 4'd8);
        end
        step(20);
        pulse_clr();
        expect_at(2, 0, 0, 1, 0, "R5");
        step(40);

        // R9: STOP holds the counter at zero
        pulse_clr();
        stop_mode = 1'b1;
        expect_at(500, 1, 0, 1, 0, "R9");
        step(600);
        stop_mode = 1'b0;
        expect_at(170, 1, 0, 1, 0, "R9");
        expect_at(215, 0, 0, 1, 1, "R9");
        step(260);

        // R3: slow tick rate
        osc_slow = 1'b1;
        pulse_clr();
        expect_at(1450, 1, 0, 1, 0, "R3");
        expect_at(1650, 0, 0, 1, 1, "R3");
        step(1700);
        osc_slow = 1'b0;
        pulse_clr();
        step(5);

        // R11: short pin pulse is ignored
        pulse_clr();
        expect_at(10, 1, 0, 0, 0, "R11");
        expect_at(22, 1, 0, 0, 0, "R11");
        expect_at(28, 1, 0, 0, 0, "R11");
        expect_at(40, 1, 0, 0, 0, "R11");
        ext_rst_n = 1'b0;
        step(20);
        ext_rst_n = 1'b1;
        step(30);

        // R10: long pin pulse resets, tail after release
        pulse_clr();
        expect_at(10, 1, 0, 0, 0, "R10");
        expect_at(35, 1, 1, 0, 0, "R10");
        expect_at(55, 1, 1, 0, 0, "R10");
        expect_at(90, 1, 0, 1, 0, "R10");
        ext_rst_n = 1'b0;
        step(40);
        ext_rst_n = 1'b1;
        step(70);

        finish_run();
    end

endmodule